// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the sequence of column addresses that one SDRAM burst walks through. A single-cycle start request captures the start column, a burst length code and an ordering type; from the next cycle on, the block presents one column per clock with a valid strobe. On the final beat of a bounded burst it also raises a last-beat flag.

Bounded bursts of 1, 2, 4 or 8 beats stay inside the aligned block of that size that holds the start column. Sequential ordering counts the low bits upward and wraps them. Interleaved ordering XORs the low bits with the beat number. Full-page mode counts through the whole 256-column row, wrapping from 255 to 0, and runs until a terminate request arrives. A new start request during a burst restarts the sequence at once from the new column.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, and whenever no burst is running, valid_o and last_o are 0 and col_o is 0.
- R2: In the cycle after a clock edge that samples start_i high, valid_o is 1 and col_o equals the low 8 bits of the sampled start_col_i.
- R3: The burst length code on len_code_i is decoded as 0 = 1 beat, 1 = 2 beats, 2 = 4 beats, 3 = 8 beats, 7 = full page. The codes 4, 5 and 6 each give a single beat. A bounded burst keeps valid_o high for exactly that many consecutive cycles.
- R4: When order_i = 0 (sequential), beat k of a bounded burst of length BL has column (S - S mod BL) + ((S mod BL + k) mod BL), where S is the start column.
- R5: When order_i = 1 (interleaved), beat k of a bounded burst has column S XOR k.
- R6: last_o is high only on beat BL-1 of a bounded burst, and valid_o is low in the following cycle unless a new start was sampled.
- R7: A full-page burst gives beat k the column (S + k) mod 256 and never ends by itself. last_o stays 0 throughout, and order_i is ignored.
- R8: A clock edge that samples terminate_i high with start_i low ends a running burst, so valid_o is 0 in the next cycle. terminate_i has no effect while the block is idle.
- R9: start_i sampled during a running burst restarts the sequence from the new start column, length and order. start_i takes priority over terminate_i.
- R10: Bits 9 and 8 of start_col_i have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst with the presented configuration |
| start_col_i | input | 10 | Start column; only bits 7:0 are used |
| len_code_i | input | 3 | Burst length code |
| order_i | input | 1 | 0 sequential, 1 interleaved |
| terminate_i | input | 1 | Stop a running burst |
| col_o | output | 8 | Current column of the burst |
| valid_o | output | 1 | col_o holds a burst beat |
| last_o | output | 1 | Final beat of a bounded burst |

## Verification
The assertions assume that start_i, terminate_i and the configuration inputs are settled around each rising edge, and that configuration inputs only matter in a cycle where start_i is high. The bench drives every input on the falling edge and changes the configuration only together with a start pulse. It also tests a start and a terminate that arrive in the same cycle, because the assertions expect start to win.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;
  typedef enum logic [2:0] {
    LEN_1    = 3'd0,
    LEN_2    = 3'd1,
    LEN_4    = 3'd2,
    LEN_8    = 3'd3,
    LEN_PAGE = 3'd7
  } len_code_e;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;
endpackage

// File: rtl/colgen_len_decode.sv
module colgen_len_decode import sdram_colgen_pkg::*; #(
  parameter int COL_W = 8
) (
  input  logic [2:0]       code_i,
  output logic [COL_W-1:0] wrap_mask_o,
  output logic             full_o
);
  always_comb begin
    full_o      = 1'b0;
    wrap_mask_o = '0;
    unique case (code_i)
      LEN_2:    wrap_mask_o = COL_W'(1);
      LEN_4:    wrap_mask_o = COL_W'(3);
      LEN_8:    wrap_mask_o = COL_W'(7);
      LEN_PAGE: begin
        wrap_mask_o = '1;
        full_o      = 1'b1;
      end
      default:  wrap_mask_o = '0; // LEN_1 and reserved codes
    endcase
  end
endmodule

// File: rtl/colgen_beat_ctrl.sv
module colgen_beat_ctrl #(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             terminate_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] wrap_mask_i,
  input  logic             full_i,
  input  logic             ilv_i,
  output logic             active_o,
  output logic             last_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] beat_o,
  output logic [COL_W-1:0] mask_o,
  output logic             ilv_o,
  output logic             full_o
);
  logic active_q, full_q, ilv_q;
  logic [COL_W-1:0] base_q, beat_q, mask_q;

  assign last_o = active_q && !full_q && (beat_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      full_q   <= 1'b0;
      ilv_q    <= 1'b0;
      base_q   <= '0;
      beat_q   <= '0;
      mask_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      full_q   <= full_i;
      ilv_q    <= ilv_i && !full_i; // full page is sequential only
      base_q   <= start_col_i;
      beat_q   <= '0;
      mask_q   <= wrap_mask_i;
    end else if (active_q) begin
      if (terminate_i || last_o) begin
        active_q <= 1'b0;
        beat_q   <= '0;
      end else begin
        beat_q   <= beat_q + COL_W'(1);
      end
    end
  end

  assign active_o = active_q;
  assign base_o   = base_q;
  assign beat_o   = beat_q;
  assign mask_o   = mask_q;
  assign ilv_o    = ilv_q;
  assign full_o   = full_q;
endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;
  assign sum = base_i + beat_i;

  // carries out of the masked field cannot leak: masks are contiguous from bit 0
  for (genvar j = 0; j < COL_W; j++) begin : g_bit
    assign col_o[j] = !mask_i[j] ? base_i[j]
                    : (ilv_i ? (base_i[j] ^ beat_i[j]) : sum[j]);
  end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W   = 8,
  parameter int START_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [START_W-1:0] start_col_i,
  input  logic [2:0]         len_code_i,
  input  logic               order_i,
  input  logic               terminate_i,
  output logic [COL_W-1:0]   col_o,
  output logic               valid_o,
  output logic               last_o
);
  logic [COL_W-1:0] dec_mask, base, beat, mask, addr;
  logic dec_full, active, ilv, full;

  colgen_len_decode #(.COL_W(COL_W)) u_dec (
    .code_i      (len_code_i),
    .wrap_mask_o (dec_mask),
    .full_o      (dec_full)
  );

  colgen_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .terminate_i (terminate_i),
    .start_col_i (start_col_i[COL_W-1:0]),
    .wrap_mask_i (dec_mask),
    .full_i      (dec_full),
    .ilv_i       (order_i),
    .active_o    (active),
    .last_o      (last_o),
    .base_o      (base),
    .beat_o      (beat),
    .mask_o      (mask),
    .ilv_o       (ilv),
    .full_o      (full)
  );

  colgen_addr_map #(.COL_W(COL_W)) u_map (
    .base_i (base),
    .beat_i (beat),
    .mask_i (mask),
    .ilv_i  (ilv),
    .col_o  (addr)
  );

  assign valid_o = active;
  assign col_o   = active ? addr : '0;
endmodule

// File: rtl/sdram_burst_colgen_chk.sv
module sdram_burst_colgen_chk #(
  parameter int COL_W   = 8,
  parameter int START_W = 10
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic [START_W-1:0] start_col_i,
  input logic               terminate_i,
  input logic [COL_W-1:0]   col_o,
  input logic               valid_o,
  input logic               last_o,
  input logic               full
);
  a_r1_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (col_o == '0 && !last_o));

  a_r2_start_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);

  // R10: only the low bits reach the column
  a_r2_first_col: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> col_o == $past(start_col_i[COL_W-1:0]));

  a_r6_last_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !valid_o);

  a_r8_term_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (terminate_i && !start_i) |=> !valid_o);

  a_r3_no_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o && !terminate_i) |=> valid_o);

  a_r7_page_no_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && full) |-> !last_o);

  a_r7_page_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && full && !start_i && !terminate_i)
      |=> col_o == COL_W'($past(col_o) + COL_W'(1)));
endmodule

bind sdram_burst_colgen sdram_burst_colgen_chk #(.COL_W(COL_W), .START_W(START_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .terminate_i (terminate_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o),
  .full        (full)
);

// File: tb/sdram_burst_colgen_tb_top.sv
module sdram_burst_colgen_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [9:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic       order_i = 1'b0;
  logic       terminate_i = 1'b0;
  logic [7:0] col_o;
  logic       valid_o, last_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  sdram_burst_colgen dut_i (
    .clk_i, .rst_ni, .start_i, .start_col_i, .len_code_i,
    .order_i, .terminate_i, .col_o, .valid_o, .last_o
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_col(int s, int bl, int ilv, int k);
    int blk;
    if (ilv != 0) return s ^ k;
    blk = s - (s % bl);
    return blk + ((s % bl + k) % bl);
  endfunction

  task automatic kick(input int col, input int code, input int ord, input bit term);
    start_i = 1'b1; start_col_i = 10'(col); len_code_i = 3'(code);
    order_i = ord[0]; terminate_i = term;
    @(negedge clk_i);
    start_i = 1'b0; terminate_i = 1'b0;
  endtask

  // full bounded burst, sampled on falling edges
  task automatic run_bounded(input int col, input int code, input int ord, input int bl, input string req);
    int s;
    s = col & 255;
    kick(col, code, ord, 1'b0);
    for (int k = 0; k < bl; k++) begin
      check({req, " valid"}, valid_o, 1);
      check(req, col_o, exp_col(s, bl, ord, k));
      check({"R6 last ", req}, last_o, (k == bl - 1) ? 1 : 0);
      @(negedge clk_i);
    end
    check({"R3 end ", req}, valid_o, 0);
    check("R1 idle col", col_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset valid", valid_o, 0);
    check("R1 reset last", last_o, 0);
    check("R1 reset col", col_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // sweep: every start column, bounded lengths, both orders (R2 R3 R4 R5)
    for (int code = 0; code < 4; code++)
      for (int ord = 0; ord < 2; ord++)
        for (int c = 0; c < 256; c++)
          run_bounded(c, code, ord, 1 << code, ord ? "R5" : "R4");

    // reserved codes act as single beat (R3)
    for (int code = 4; code < 7; code++) run_bounded(37, code, 0, 1, "R3 rsv");

    // upper start bits ignored (R10)
    run_bounded(10'h3A5, 3, 0, 8, "R10");
    run_bounded(10'h1FE, 2, 1, 4, "R10");

    // full page, interleave request ignored, wrap 255->0 (R7)
    kick(250, 7, 1, 1'b0);
    for (int k = 0; k < 300; k++) begin
      check("R7 valid", valid_o, 1);
      check("R7 col", col_o, (250 + k) % 256);
      check("R7 last", last_o, 0);
      @(negedge clk_i);
    end
    terminate_i = 1'b1;                 // R8
    @(negedge clk_i);
    terminate_i = 1'b0;
    check("R8 stop", valid_o, 0);
    check("R8 col", col_o, 0);
    terminate_i = 1'b1;                 // R8 idle: no effect
    @(negedge clk_i);
    terminate_i = 1'b0;
    check("R8 idle", valid_o, 0);
    run_bounded(8, 1, 0, 2, "R8 after");

    // terminate mid bounded burst (R8)
    kick(16, 3, 0, 1'b0);
    @(negedge clk_i);
    check("R8 mid col", col_o, 17);
    terminate_i = 1'b1;
    @(negedge clk_i);
    terminate_i = 1'b0;
    check("R8 mid stop", valid_o, 0);

    // restart mid burst, start beats terminate (R9)
    kick(5, 3, 0, 1'b0);
    check("R9 b0", col_o, 5);
    @(negedge clk_i);
    @(negedge clk_i);
    check("R9 b2", col_o, 7);
    kick(10'h042, 2, 1, 1'b1);
    for (int k = 0; k < 4; k++) begin
      check("R9 valid", valid_o, 1);
      check("R9 col", col_o, 8'h42 ^ k);
      check("R9 last", last_o, (k == 3) ? 1 : 0);
      @(negedge clk_i);
    end
    check("R9 end", valid_o, 0);

    // restart on the last beat of a burst (R9)
    kick(3, 1, 0, 1'b0);
    @(negedge clk_i);
    check("R9 last beat", last_o, 1);
    kick(200, 0, 0, 1'b0);
    check("R9 rst col", col_o, 200);
    check("R9 rst last", last_o, 1);
    @(negedge clk_i);
    check("R9 rst end", valid_o, 0);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule